// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front-End

This block is the slave-side SPI front-end of a small byte-organised nonvolatile memory. It runs entirely on the system clock. SCK, CS_n and SI are oversampled through a synchroniser, and the bus edges are recovered from the synchronised samples. Each frame starts with a one-byte instruction, shifted in MSB first. The front-end decodes six commands: set the write-enable latch, clear the write-enable latch, read the status byte, write the status byte, read memory and write memory.

A memory read captures an address and then streams bytes out on SO. The address advances after each byte and wraps around the array. A memory write collects its data bytes in a page latch. On a correctly framed deselect, the latch is committed to the internal array, and a one-cycle pulse starts an external write-cycle timer. That timer reports back through a busy input, which appears as the write-in-progress status bit.

The write-enable latch, the busy state and a two-bit block-guard field all decide whether a write is accepted. Commands that end on the wrong clock count are cancelled and leave no trace.

Top module: `spi_eeprom_front`

## Requirements
- R1: SI is sampled on each SCK rising edge and SO changes only after SCK falling edges, MSB first. Both idle-low (mode 0) and idle-high (mode 3) clocking give identical results.
- R2: An instruction byte is valid only when bits 7:4 are 0000. Bits 2:0 select the command: 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads memory, 010 writes memory. Bit 3 carries no meaning for the first four of these.
- R3: An invalid instruction makes the block ignore the rest of the frame, and SO stays undriven until CS_n has gone high and low again.
- R4: After a memory-read instruction and its address byte (16 clocks), the byte at that address is shifted out. Each further 8 clocks output the next address, and the address after DEPTH-1 is 0.
- R5: With DEPTH 512, instruction bit 3 supplies address bit 8 for memory read and memory write. The following byte supplies bits 7:0.
- R6: The set and clear write-enable instructions change the latch only if CS_n rises after exactly 8 clocks.
- R7: The status byte is {1111, guard[1], guard[0], write-enable, busy_i}, with bit 7 on the left. It can be read at any time, including while busy_i is high, and it repeats every 8 further clocks.
- R8: A status write takes effect only with exactly 16 clocks, while the latch is set and busy_i is low. Data bits 3:2 then become guard[1:0], the latch clears, and prog_start_o pulses for one cycle.
- R9: A memory write takes effect only with 16+8m clocks (m>=1), while the latch is set and busy_i is low. The address advances only in its low 4 bits within a 16-byte page, so later bytes overwrite earlier ones. On commit, the latch clears and prog_start_o pulses for one cycle. On any other clock count, nothing changes.
- R10: The guard field blocks memory writes whose start address lies in a protected region: guard 00 protects nothing, 01 the top quarter, 10 the top half, and 11 the whole array.
- R11: A memory-read instruction received while busy_i is high is ignored, and SO stays undriven for that frame.
- R12: so_oe_o is high only while CS_n is low and read or status data is being shifted out.
- R13: After reset, the write-enable latch and the guard field are 0, every memory byte reads FF, and so_oe_o and prog_start_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| si_i | input | 1 | SPI serial data in |
| busy_i | input | 1 | Write cycle in progress, from the external write timer |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| prog_start_o | output | 1 | One-cycle pulse that starts an external write cycle |

## Verification
A wrong bit or byte counter shows up in two ways. A read stream appears shifted by a bit at the first sampled byte, and the exact-count rule for an enable, status or memory write either applies a cancelled command or cancels a good one. That second error becomes visible at the next status read or read-back. A wrong page index or address increment corrupts the read-back of the affected page, or the byte that follows a wrap. A stale guard or latch value lets a forbidden write through or blocks an allowed one, and this shows as a data mismatch or a missing prog_start_o pulse within two cycles of CS_n rising.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_SINGLE, ST_SR_OUT,
    ST_SR_IN, ST_RD, ST_WR, ST_DESEL
  } fe_state_e;

  localparam logic [2:0] OP_SET_WE = 3'b110;
  localparam logic [2:0] OP_CLR_WE = 3'b100;
  localparam logic [2:0] OP_RD_SR  = 3'b101;
  localparam logic [2:0] OP_WR_SR  = 3'b001;
  localparam logic [2:0] OP_READ   = 3'b011;
  localparam logic [2:0] OP_WRITE  = 3'b010;

  // top2 = two address MSBs
  function automatic logic in_guard(input logic [1:0] guard, input logic [1:0] top2);
    case (guard)
      2'b00:   in_guard = 1'b0;
      2'b01:   in_guard = (top2 == 2'b11);
      2'b10:   in_guard = top2[1];
      default: in_guard = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic si_o
);
  localparam int S = SYNC_STAGES;

  logic [S:0]   sck_q;
  logic [S:0]   cs_q;
  logic [S-1:0] si_q;
  logic         cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[S-1:0], sck_i};
      cs_q  <= {cs_q[S-1:0], cs_ni};
      si_q  <= {si_q[S-2:0], si_i};
    end
  end

  assign cs_act     = !cs_q[S-1];
  assign sck_rise_o = cs_act && sck_q[S-1] && !sck_q[S];
  assign sck_fall_o = cs_act && !sck_q[S-1] && sck_q[S];
  assign cs_rise_o  = cs_q[S-1] && !cs_q[S];
  assign cs_fall_o  = !cs_q[S-1] && cs_q[S];
  assign si_o       = si_q[S-1];

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  input  logic          pl_clr_i,
  input  logic          pl_we_i,
  input  logic [PW-1:0] pl_idx_i,
  input  logic [7:0]    pl_data_i,
  input  logic          commit_i,
  input  logic [AW-PW-1:0] page_i
);
  logic [7:0]      mem_q [DEPTH];
  logic [7:0]      pl_q  [PAGE];
  logic [PAGE-1:0] pl_vld_q;

  for (genvar g = 0; g < PAGE; g++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pl_q[g]     <= '0;
        pl_vld_q[g] <= 1'b0;
      end else if (pl_clr_i) begin
        pl_vld_q[g] <= 1'b0;
      end else if (pl_we_i && pl_idx_i == PW'(g)) begin
        pl_q[g]     <= pl_data_i;
        pl_vld_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE; i++)
        if (pl_vld_q[i]) mem_q[{page_i, PW'(i)}] <= pl_q[i];
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_commit_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (!pl_we_i && !pl_clr_i));

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          cs_rise_i,
  input  logic          cs_fall_i,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          pl_clr_o,
  output logic          pl_we_o,
  output logic [PW-1:0] pl_idx_o,
  output logic [7:0]    pl_data_o,
  output logic          commit_o,
  output logic [AW-PW-1:0] page_o,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          prog_start_o
);
  fe_state_e     state_q;
  logic [2:0]    bit_cnt_q;
  logic [1:0]    byte_cnt_q;   // saturates at 3
  logic [6:0]    sh_q;
  logic          a8_q, is_wr_q, set_we_q, wel_q;
  logic [1:0]    guard_q, sr_new_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [7:0]    out_byte_q;
  logic [2:0]    out_idx_q;
  logic          so_q, oe_q, prog_q, commit_q;

  logic [7:0]    byte_w, status_w;
  logic [8:0]    full_addr;
  logic [AW-1:0] addr_w;
  logic          byte_done, addr_guarded;

  assign byte_w       = {sh_q, si_i};
  assign byte_done    = sck_rise_i && (bit_cnt_q == 3'd7);
  assign full_addr    = {a8_q, byte_w};
  assign addr_w       = full_addr[AW-1:0];
  assign addr_guarded = in_guard(guard_q, addr_w[AW-1 -: 2]);
  assign status_w     = {4'hF, guard_q, wel_q, busy_i};

  assign raddr_o   = (state_q == ST_ADDR) ? addr_w : rd_addr_q + AW'(1);
  assign pl_clr_o  = byte_done && (state_q == ST_ADDR) && is_wr_q && !addr_guarded;
  assign pl_we_o   = byte_done && (state_q == ST_WR);
  assign pl_idx_o  = wr_addr_q[PW-1:0];
  assign pl_data_o = byte_w;
  assign page_o    = wr_addr_q[AW-1:PW];
  assign commit_o  = commit_q;
  assign so_o      = so_q;
  assign so_oe_o   = oe_q;
  assign prog_start_o = prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      sh_q       <= '0;
      a8_q       <= 1'b0;
      is_wr_q    <= 1'b0;
      set_we_q   <= 1'b0;
      wel_q      <= 1'b0;
      guard_q    <= '0;
      sr_new_q   <= '0;
      rd_addr_q  <= '0;
      wr_addr_q  <= '0;
      out_byte_q <= '0;
      out_idx_q  <= '0;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
      prog_q     <= 1'b0;
      commit_q   <= 1'b0;
    end else begin
      prog_q   <= 1'b0;
      commit_q <= 1'b0;
      if (cs_rise_i) begin
        // exact clock count decides whether the frame commits
        if (bit_cnt_q == 3'd0) begin
          case (state_q)
            ST_SINGLE: if (byte_cnt_q == 2'd1) wel_q <= set_we_q;
            ST_SR_IN: if (byte_cnt_q == 2'd2) begin
              guard_q <= sr_new_q;
              wel_q   <= 1'b0;
              prog_q  <= 1'b1;
            end
            ST_WR: if (byte_cnt_q == 2'd3) begin
              wel_q    <= 1'b0;
              prog_q   <= 1'b1;
              commit_q <= 1'b1;
            end
            default: ;
          endcase
        end
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (cs_fall_i) begin
        state_q    <= ST_OPC;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        oe_q       <= 1'b0;
      end else if (sck_rise_i && state_q != ST_IDLE) begin
        sh_q      <= byte_w[6:0];
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (byte_done && byte_cnt_q != 2'd3) byte_cnt_q <= byte_cnt_q + 2'd1;
        if (byte_done) begin
          case (state_q)
            ST_OPC: begin
              a8_q <= byte_w[3];
              if (byte_w[7:4] != 4'h0) state_q <= ST_DESEL;
              else begin
                case (byte_w[2:0])
                  OP_SET_WE: begin state_q <= ST_SINGLE; set_we_q <= 1'b1; end
                  OP_CLR_WE: begin state_q <= ST_SINGLE; set_we_q <= 1'b0; end
                  OP_RD_SR: begin
                    state_q    <= ST_SR_OUT;
                    out_byte_q <= status_w;
                    out_idx_q  <= 3'd7;
                  end
                  OP_WR_SR: state_q <= (wel_q && !busy_i) ? ST_SR_IN : ST_DESEL;
                  OP_READ: begin
                    state_q <= busy_i ? ST_DESEL : ST_ADDR;
                    is_wr_q <= 1'b0;
                  end
                  OP_WRITE: begin
                    state_q <= (wel_q && !busy_i) ? ST_ADDR : ST_DESEL;
                    is_wr_q <= 1'b1;
                  end
                  default: state_q <= ST_DESEL;
                endcase
              end
            end
            ST_ADDR: begin
              if (!is_wr_q) begin
                rd_addr_q  <= addr_w;
                out_byte_q <= rdata_i;
                out_idx_q  <= 3'd7;
                state_q    <= ST_RD;
              end else if (addr_guarded) begin
                state_q <= ST_DESEL;
              end else begin
                wr_addr_q <= addr_w;
                state_q   <= ST_WR;
              end
            end
            ST_SR_IN: sr_new_q <= byte_w[3:2];
            ST_WR: wr_addr_q[PW-1:0] <= wr_addr_q[PW-1:0] + PW'(1);
            default: ;
          endcase
        end
      end else if (sck_fall_i && (state_q == ST_RD || state_q == ST_SR_OUT)) begin
        so_q <= out_byte_q[out_idx_q];
        oe_q <= 1'b1;
        if (out_idx_q == 3'd0) begin
          out_idx_q <= 3'd7;
          if (state_q == ST_RD) begin
            rd_addr_q  <= rd_addr_q + AW'(1);
            out_byte_q <= rdata_i;
          end else begin
            out_byte_q <= status_w;
          end
        end else begin
          out_idx_q <= out_idx_q - 3'd1;
        end
      end
    end
  end

  assert_oe_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !so_oe_o);
  assert_wel_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(wel_q));
  assert_guard_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(guard_q));
  assert_prog_on_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(cs_rise_i));
  assert_commit_unguarded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> !in_guard(guard_q, wr_addr_q[AW-1 -: 2]));
  assert_read_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_OPC && byte_w[7:4] == 4'h0 &&
     byte_w[2:0] == OP_READ && busy_i) |=> (state_q == ST_DESEL));

endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front #(
  parameter int DEPTH       = 512,
  parameter int PAGE        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic busy_i,
  output logic so_o,
  output logic so_oe_o,
  output logic prog_start_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic sck_rise, sck_fall, cs_rise, cs_fall, si_s;
  logic [AW-1:0]    raddr;
  logic [7:0]       rdata, pl_data;
  logic             pl_clr, pl_we, commit;
  logic [PW-1:0]    pl_idx;
  logic [AW-PW-1:0] page;

  spi_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_rise_o(cs_rise), .cs_fall_o(cs_fall), .si_o(si_s)
  );

  spi_ee_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) i_ctrl (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_rise_i(cs_rise), .cs_fall_i(cs_fall), .si_i(si_s),
    .busy_i, .rdata_i(rdata), .raddr_o(raddr),
    .pl_clr_o(pl_clr), .pl_we_o(pl_we), .pl_idx_o(pl_idx), .pl_data_o(pl_data),
    .commit_o(commit), .page_o(page),
    .so_o, .so_oe_o, .prog_start_o
  );

  spi_ee_store #(.DEPTH(DEPTH), .PAGE(PAGE)) i_store (
    .clk_i, .rst_ni, .raddr_i(raddr), .rdata_o(rdata),
    .pl_clr_i(pl_clr), .pl_we_i(pl_we), .pl_idx_i(pl_idx), .pl_data_i(pl_data),
    .commit_i(commit), .page_i(page)
  );

endmodule

// File: tb/test_spi_eeprom_front.sv
module test_spi_eeprom_front;
  localparam int H = 6;  // system clocks per SCK half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
  logic so, so_oe, prog;

  spi_eeprom_front i_spi_eeprom_front (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .busy_i(busy), .so_o(so), .so_oe_o(so_oe), .prog_start_o(prog)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0, prog_cnt = 0, exp_prog = 0;
  logic [7:0] tx [0:39];
  logic [7:0] rx [0:39];
  logic       oe_any;
  logic [7:0] m_mem [0:511];
  logic       m_wel = 1'b0;
  logic [1:0] m_guard = 2'b00;
  logic [7:0] wbuf [0:31];

  always @(posedge clk) if (prog) prog_cnt++;

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nclk, input bit m3);
    sck = m3; hw(H);
    cs_n = 1'b0; oe_any = 1'b0; hw(H);
    for (int b = 0; b < nclk; b++) begin
      sck = 1'b0; si = tx[b/8][7-(b%8)]; hw(H);
      rx[b/8][7-(b%8)] = so; oe_any |= so_oe;
      sck = 1'b1; hw(H);
    end
    if (!m3) begin sck = 1'b0; hw(H); end
    cs_n = 1'b1; hw(2*H);
  endtask

  function automatic logic guarded(input logic [1:0] g, input logic [8:0] a);
    case (g)
      2'b00: return 1'b0;
      2'b01: return a[8:7] == 2'b11;
      2'b10: return a[8];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {4'hF, m_guard, m_wel, busy};
  endfunction

  task automatic read_status(output logic [7:0] s);
    tx[0] = 8'h05; frame(16, 1'b0); s = rx[1];
  endtask

  task automatic single(input logic [7:0] op, input int nclk);
    tx[0] = op; frame(nclk, 1'b0);
    if (nclk == 8 && op[7:4] == 0 && op[2:0] == 3'b110) m_wel = 1'b1;
    if (nclk == 8 && op[7:4] == 0 && op[2:0] == 3'b100) m_wel = 1'b0;
  endtask

  task automatic write_mem(input logic [8:0] a, input int n, input int extra);
    tx[0] = {4'h0, a[8], 3'b010}; tx[1] = a[7:0];
    for (int i = 0; i < n + 1; i++) tx[2+i] = wbuf[i];
    frame(16 + 8*n + extra, 1'b0);
    if (extra == 0 && n > 0 && m_wel && !busy && !guarded(m_guard, a)) begin
      for (int i = 0; i < n; i++) m_mem[{a[8:4], 4'(a[3:0] + i)}] = wbuf[i];
      m_wel = 1'b0; exp_prog++;
    end
  endtask

  task automatic read_mem(input logic [8:0] a, input int n, input bit m3);
    tx[0] = {4'h0, a[8], 3'b011}; tx[1] = a[7:0];
    for (int i = 0; i < n; i++) tx[2+i] = 8'h00;
    frame(16 + 8*n, m3);
  endtask

  task automatic check_read(input string tag, input logic [8:0] a, input int n, input bit m3);
    read_mem(a, n, m3);
    for (int i = 0; i < n; i++) chk(tag, rx[2+i], m_mem[9'(a + i)]);
  endtask

  logic [7:0] s;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
    hw(5); rst_n = 1'b1; hw(5);

    chk("R13 reset so_oe", so_oe, 0);
    chk("R13 reset prog_start", prog, 0);
    read_status(s); chk("R13 status after reset", s, 8'hF0);
    chk("R12 oe during status read", oe_any, 1);
    check_read("R13 erased byte", 9'h000, 2, 1'b0);

    single(8'h0E, 8); read_status(s); chk("R2 set-enable with bit3", s, exp_status());
    single(8'h0C, 8); read_status(s); chk("R2 clear-enable with bit3", s, exp_status());
    single(8'h06, 9); read_status(s); chk("R6 set-enable 9 clocks cancelled", s, 8'hF0);
    single(8'h06, 8); read_status(s); chk("R6 set-enable 8 clocks", s, 8'hF2);
    single(8'h04, 16); read_status(s); chk("R6 clear-enable 16 clocks cancelled", s, 8'hF2);
    single(8'h04, 8);

    wbuf[0] = 8'h5A; write_mem(9'h010, 1, 0);
    check_read("R9 write without latch ignored", 9'h010, 1, 1'b0);
    chk("R9 no pulse without latch", prog_cnt, exp_prog);

    single(8'h06, 8);
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h30 + i);
    write_mem(9'h03E, 18, 0);
    chk("R9 commit pulse", prog_cnt, exp_prog);
    read_status(s); chk("R9 latch cleared", s, 8'hF0);
    check_read("R9 page wrap", 9'h030, 16, 1'b0);

    single(8'h06, 8);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; write_mem(9'h050, 1, 3);
    check_read("R9 odd count cancelled", 9'h050, 1, 1'b0);
    read_status(s); chk("R9 latch kept on cancel", s, 8'hF2);
    write_mem(9'h050, 0, 0);
    read_status(s); chk("R9 no data bytes cancelled", s, 8'hF2);

    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; write_mem(9'h1A3, 2, 0);
    check_read("R5 high half via bit3", 9'h1A3, 2, 1'b0);
    check_read("R5 low half untouched", 9'h0A3, 2, 1'b0);

    single(8'h06, 8);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; write_mem(9'h1FE, 2, 0);
    single(8'h06, 8);
    wbuf[0] = 8'h33; wbuf[1] = 8'h44; write_mem(9'h000, 2, 0);
    check_read("R4 address wrap", 9'h1FE, 4, 1'b0);
    check_read("R1 mode 3 read", 9'h1FE, 4, 1'b1);

    single(8'h06, 8);
    tx[0] = 8'h01; tx[1] = 8'h04; frame(16, 1'b0);
    m_guard = 2'b01; m_wel = 1'b0; exp_prog++;
    read_status(s); chk("R8 status write", s, 8'hF4);
    chk("R8 pulse", prog_cnt, exp_prog);
    single(8'h06, 8);
    tx[0] = 8'h01; tx[1] = 8'h0C; frame(24, 1'b0);
    read_status(s); chk("R8 24 clocks cancelled", s, 8'hF6);
    wbuf[0] = 8'h77; write_mem(9'h190, 1, 0);
    check_read("R10 guarded top quarter", 9'h190, 1, 1'b0);
    write_mem(9'h170, 1, 0);
    check_read("R10 below guard written", 9'h170, 1, 1'b0);
    single(8'h06, 8);
    tx[0] = 8'h01; tx[1] = 8'h08; frame(16, 1'b0); m_guard = 2'b10; m_wel = 1'b0; exp_prog++;
    single(8'h06, 8);
    wbuf[0] = 8'h66; write_mem(9'h120, 1, 0);
    check_read("R10 guarded top half", 9'h120, 1, 1'b0);
    read_status(s); chk("R10 latch kept when guarded", s, 8'hFA);

    busy = 1'b1;
    tx[0] = 8'h05; frame(24, 1'b0);
    chk("R7 status while busy", rx[1], exp_status());
    chk("R7 status repeats", rx[2], exp_status());
    read_mem(9'h170, 2, 1'b0);
    chk("R11 read ignored while busy", oe_any, 0);
    wbuf[0] = 8'h99; write_mem(9'h020, 1, 0);
    busy = 1'b0;
    check_read("R9 write while busy ignored", 9'h020, 1, 1'b0);
    chk("R8 pulse count", prog_cnt, exp_prog);

    tx[0] = 8'h07; tx[1] = 8'h00; tx[2] = 8'h00; frame(32, 1'b0);
    chk("R3 invalid low code undriven", oe_any, 0);
    tx[0] = 8'h83; frame(32, 1'b0);
    chk("R2 nonzero upper nibble undriven", oe_any, 0);
    read_status(s); chk("R3 status unchanged", s, exp_status());
    chk("R12 oe low after deselect", so_oe, 0);

    single(8'h06, 8);
    tx[0] = 8'h01; tx[1] = 8'h00; frame(16, 1'b0); m_guard = 2'b00; m_wel = 1'b0; exp_prog++;
    for (int it = 0; it < 12; it++) begin
      logic [8:0] a;
      int n;
      a = 9'($urandom);
      n = 1 + int'($urandom % 8);
      if ($urandom % 4 != 0) single(8'h06, 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_mem(a, n, 0);
      check_read("R4 random read-back", {a[8:4], 4'h0}, 16, ($urandom % 2) == 1);
      read_status(s); chk("R7 random status", s, exp_status());
    end
    chk("R9 final pulse count", prog_cnt, exp_prog);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule